// File: doc/BRIEF.md
# Scaler phase parameter calculator

This block turns a request to resize one image plane into the settings a polyphase upscaler is programmed with. A caller presents a per-plane request mask, the source width and height in unsigned 16.16 fixed point, and the integer destination width and height, then pulses `start`. The block captures these values. It checks that the request can be served. It then runs a sequence of integer divisions on a single shared restoring divider and raises `done` for one cycle. At that point either `err` or `scale_en` describes the outcome, and the size, phase and coefficient-set outputs hold the results.

The control is one state machine with six named states. `S_IDLE` waits for `start`. `S_CHECK` judges the captured mask and dimensions. `S_LAUNCH` hands the operands of the current division to the divider. `S_WAIT` waits for the quotient and stores it. `S_JUDGE` sits between the two scale-factor divisions and the four phase divisions, and rejects a downscale. `S_DONE` reports the outcome for one cycle.

The transitions are:
- IDLE→CHECK on `start`.
- CHECK→DONE for an empty mask, more than one mask bit, or a zero dimension.
- CHECK→LAUNCH otherwise.
- LAUNCH→WAIT always.
- WAIT→LAUNCH after an intermediate division.
- WAIT→JUDGE after the vertical factor.
- WAIT→DONE after the last phase division.
- JUDGE→DONE on a downscale.
- JUDGE→LAUNCH otherwise.
- DONE→CHECK on `start`.
- DONE→IDLE otherwise.

The divisions run in a fixed order: horizontal factor, vertical factor, horizontal initial phase, horizontal step, vertical initial phase, vertical step.

Top module: `scale_param_calc`

## Requirements
- R1: After reset `busy`, `done`, `err` and `scale_en` are all 0.
- R2: A request whose mask is zero ends with `done`, `err`=0 and `scale_en`=0, whatever the dimensions are.
- R3: A mask with more than one bit set (mask AND (mask−1) non-zero) ends with `err`=1 and `scale_en`=0.
- R4: A one-bit mask with any source or destination dimension equal to zero ends with `err`=1 and `scale_en`=0.
- R5: For each axis the factor is ((destination << 32) / source), keeping the low 32 bits as a 16.16 value. If bits 31:16 of either axis factor are zero, the request ends with `err`=1 and `scale_en`=0.
- R6: On success, `scale_en`=1 and `err`=0. `in_w`/`in_h` equal the source sizes shifted right by 16, and `out_w`/`out_h` equal the destination sizes.
- R7: On success, each axis initial phase equals (((in << 4) / out) + 1) / 2, using integer division.
- R8: On success, each axis phase step equals (in << 16) / out, using integer division.
- R9: `h_coef`/`v_coef` give the coefficient set of each axis factor, and they are valid after success and after a downscale rejection. The encoding is: factor ≥ 0x10000 gives 1, ≥ 0xAAAA gives 2, ≥ 0x8000 gives 3, ≥ 0x5D17 gives 4, and anything lower gives 5.
- R10: When exactly one mask bit is set, `plane_id` is the index of that bit (bit 0 gives 0).
- R11: `busy` is 1 in the cycle after an accepted `start` and until the result. `done` is a single-cycle pulse. A `start` while `busy` is 1 is ignored, and the request in progress completes with its own values.
- R12: A `start` in the same cycle as `done` is accepted, and the new request is processed and reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request pulse; accepted when `busy` is 0 |
| req_mask | input | NPLANES | One bit per plane asking for scaling |
| src_w | input | DIM_W+16 | Source width, 16.16 |
| src_h | input | DIM_W+16 | Source height, 16.16 |
| dst_w | input | DIM_W | Destination width |
| dst_h | input | DIM_W | Destination height |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected |
| scale_en | output | 1 | Request accepted; results valid |
| plane_id | output | $clog2(NPLANES) | Index of the selected plane |
| in_w | output | DIM_W | Integer input width |
| in_h | output | DIM_W | Integer input height |
| out_w | output | DIM_W | Output width |
| out_h | output | DIM_W | Output height |
| h_init | output | 32 | Horizontal initial phase |
| h_step | output | 32 | Horizontal phase step |
| v_init | output | 32 | Vertical initial phase |
| v_step | output | 32 | Vertical phase step |
| h_coef | output | 3 | Horizontal coefficient set |
| v_coef | output | 3 | Vertical coefficient set |

## Verification
Reporting a finished request and accepting the next one can fall in the same cycle. The bench provokes this by raising `start` with a fresh request in exactly the cycle where `done` is observed high. It judges the result by requiring `busy` one cycle later and then the second request's sizes and phases at the next `done`. It also presents a competing `start` in the middle of a division, and requires the first request's values to come out unchanged.

// File: rtl/scl_pkg.sv
package scl_pkg;
    localparam int FAC_W   = 32;
    localparam int FRAC    = 16;
    localparam int INIT_SH = 4;
    localparam int STEP_SH = 16;
    localparam int COEF_W  = 3;

    localparam logic [FAC_W-1:0] TH_UNITY = 32'h0001_0000;
    localparam logic [FAC_W-1:0] TH_A     = 32'h0000_AAAA;
    localparam logic [FAC_W-1:0] TH_B     = 32'h0000_8000;
    localparam logic [FAC_W-1:0] TH_C     = 32'h0000_5D17;

    typedef logic [COEF_W-1:0] coef_t;
    localparam coef_t SET_UP = 3'd1;
    localparam coef_t SET_A  = 3'd2;
    localparam coef_t SET_B  = 3'd3;
    localparam coef_t SET_C  = 3'd4;
    localparam coef_t SET_D  = 3'd5;

    typedef enum logic [2:0] {
        S_IDLE, S_CHECK, S_LAUNCH, S_WAIT, S_JUDGE, S_DONE
    } fsm_t;

    typedef enum logic [2:0] {
        OP_HFAC, OP_VFAC, OP_HINIT, OP_HSTEP, OP_VINIT, OP_VSTEP
    } op_t;
endpackage

// File: rtl/scl_divider.sv
module scl_divider #(
    parameter int DVD_W = 48,
    parameter int DVS_W = 32,
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic             busy,
    output logic             fin,
    output logic [OUT_W-1:0] quo
);
    localparam int CNT_W = $clog2(DVD_W + 1);

    logic [DVD_W-1:0] q_sh;
    logic [DVS_W-1:0] rem;
    logic [DVS_W-1:0] dvs;
    logic [CNT_W-1:0] cnt;
    logic             busy_q, fin_q;
    logic [DVS_W:0]   shifted, trial;
    logic             fits;

    always_comb begin
        shifted = {rem, q_sh[DVD_W-1]};
        trial   = shifted - {1'b0, dvs};
        fits    = !trial[DVS_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_sh   <= '0;
            rem    <= '0;
            dvs    <= '0;
            cnt    <= '0;
            busy_q <= 1'b0;
            fin_q  <= 1'b0;
        end else if (go) begin
            q_sh   <= dividend;
            rem    <= '0;
            dvs    <= divisor;
            cnt    <= CNT_W'(DVD_W);
            busy_q <= 1'b1;
            fin_q  <= 1'b0;
        end else if (busy_q) begin
            q_sh <= {q_sh[DVD_W-2:0], fits};
            rem  <= fits ? trial[DVS_W-1:0] : shifted[DVS_W-1:0];
            cnt  <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
                busy_q <= 1'b0;
                fin_q  <= 1'b1;
            end
        end else begin
            fin_q <= 1'b0;
        end
    end

    assign busy = busy_q;
    assign fin  = fin_q;
    assign quo  = q_sh[OUT_W-1:0];

    // R11: completion of a division is a single-cycle event
    assert_fin_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);
    // R11: the sequencer never relaunches a division in flight
    assert_no_go_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy_q);
endmodule

// File: rtl/scl_req_check.sv
module scl_req_check #(
    parameter int NPLANES = 4,
    parameter int PID_W   = 2
) (
    input  logic [NPLANES-1:0] mask,
    output logic               empty,
    output logic               multi,
    output logic [PID_W-1:0]   pid
);
    assign empty = (mask == '0);
    assign multi = |(mask & (mask - NPLANES'(1)));

    always_comb begin
        pid = '0;
        for (int i = 0; i < NPLANES; i++) begin
            if (mask[i]) pid = PID_W'(i);
        end
    end
endmodule

// File: rtl/scl_coef_sel.sv
module scl_coef_sel
    import scl_pkg::*;
(
    input  logic [FAC_W-1:0] factor,
    output coef_t            set
);
    always_comb begin
        if (factor >= TH_UNITY)  set = SET_UP;
        else if (factor >= TH_A) set = SET_A;
        else if (factor >= TH_B) set = SET_B;
        else if (factor >= TH_C) set = SET_C;
        else                     set = SET_D;
    end
endmodule

// File: rtl/scale_param_calc.sv
module scale_param_calc
    import scl_pkg::*;
#(
    parameter int NPLANES = 4,
    parameter int DIM_W   = 16,
    localparam int SRC_W  = DIM_W + FRAC,
    localparam int PID_W  = (NPLANES > 1) ? $clog2(NPLANES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [NPLANES-1:0] req_mask,
    input  logic [SRC_W-1:0]   src_w,
    input  logic [SRC_W-1:0]   src_h,
    input  logic [DIM_W-1:0]   dst_w,
    input  logic [DIM_W-1:0]   dst_h,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic               scale_en,
    output logic [PID_W-1:0]   plane_id,
    output logic [DIM_W-1:0]   in_w,
    output logic [DIM_W-1:0]   in_h,
    output logic [DIM_W-1:0]   out_w,
    output logic [DIM_W-1:0]   out_h,
    output logic [FAC_W-1:0]   h_init,
    output logic [FAC_W-1:0]   h_step,
    output logic [FAC_W-1:0]   v_init,
    output logic [FAC_W-1:0]   v_step,
    output logic [COEF_W-1:0]  h_coef,
    output logic [COEF_W-1:0]  v_coef
);
    localparam int DVD_W = DIM_W + FAC_W;

    fsm_t state, state_nx;
    op_t  op;

    logic [NPLANES-1:0] cap_mask;
    logic [SRC_W-1:0]   cap_sw, cap_sh;
    logic [DIM_W-1:0]   cap_dw, cap_dh;
    logic [FAC_W-1:0]   h_fac, v_fac;
    logic [FAC_W-1:0]   h_init_q, h_step_q, v_init_q, v_step_q;
    logic               err_q, en_q;

    logic               accept;
    logic               set_res, res_err, res_en;
    logic               m_empty, m_multi, dim_zero;
    logic               div_go, div_busy, div_fin;
    logic [DVD_W-1:0]   div_dvd;
    logic [SRC_W-1:0]   div_dvs;
    logic [FAC_W-1:0]   div_quo;
    logic [DIM_W-1:0]   iw, ih;

    assign iw = cap_sw[SRC_W-1:FRAC];
    assign ih = cap_sh[SRC_W-1:FRAC];

    scl_req_check #(.NPLANES(NPLANES), .PID_W(PID_W)) u_req (
        .mask(cap_mask), .empty(m_empty), .multi(m_multi), .pid(plane_id)
    );

    scl_coef_sel u_hcoef (.factor(h_fac), .set(h_coef));
    scl_coef_sel u_vcoef (.factor(v_fac), .set(v_coef));

    scl_divider #(.DVD_W(DVD_W), .DVS_W(SRC_W), .OUT_W(FAC_W)) u_div (
        .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(div_dvd),
        .divisor(div_dvs), .busy(div_busy), .fin(div_fin), .quo(div_quo)
    );

    assign busy     = (state != S_IDLE) && (state != S_DONE);
    assign accept   = start && !busy;
    assign dim_zero = (cap_sw == '0) || (cap_sh == '0) ||
                      (cap_dw == '0) || (cap_dh == '0);

    // operand selection for the division in progress
    always_comb begin
        div_dvd = '0;
        div_dvs = '0;
        unique case (op)
            OP_HFAC: begin
                div_dvd = {cap_dw, {FAC_W{1'b0}}};
                div_dvs = cap_sw;
            end
            OP_VFAC: begin
                div_dvd = {cap_dh, {FAC_W{1'b0}}};
                div_dvs = cap_sh;
            end
            OP_HINIT: begin
                div_dvd = DVD_W'(iw) << INIT_SH;
                div_dvs = SRC_W'(cap_dw);
            end
            OP_HSTEP: begin
                div_dvd = DVD_W'(iw) << STEP_SH;
                div_dvs = SRC_W'(cap_dw);
            end
            OP_VINIT: begin
                div_dvd = DVD_W'(ih) << INIT_SH;
                div_dvs = SRC_W'(cap_dh);
            end
            OP_VSTEP: begin
                div_dvd = DVD_W'(ih) << STEP_SH;
                div_dvs = SRC_W'(cap_dh);
            end
            default: ;
        endcase
    end

    // next state and outcome
    always_comb begin
        state_nx = state;
        set_res  = 1'b0;
        res_err  = 1'b0;
        res_en   = 1'b0;
        div_go   = 1'b0;
        unique case (state)
            S_IDLE:   if (start) state_nx = S_CHECK;
            S_CHECK: begin
                if (m_empty) begin
                    state_nx = S_DONE;
                    set_res  = 1'b1;
                end else if (m_multi || dim_zero) begin
                    state_nx = S_DONE;
                    set_res  = 1'b1;
                    res_err  = 1'b1;
                end else begin
                    state_nx = S_LAUNCH;
                end
            end
            S_LAUNCH: begin
                div_go   = 1'b1;
                state_nx = S_WAIT;
            end
            S_WAIT: begin
                if (div_fin) begin
                    if (op == OP_VFAC) begin
                        state_nx = S_JUDGE;
                    end else if (op == OP_VSTEP) begin
                        state_nx = S_DONE;
                        set_res  = 1'b1;
                        res_en   = 1'b1;
                    end else begin
                        state_nx = S_LAUNCH;
                    end
                end
            end
            S_JUDGE: begin
                if (h_fac[FAC_W-1:FRAC] == '0 || v_fac[FAC_W-1:FRAC] == '0) begin
                    state_nx = S_DONE;
                    set_res  = 1'b1;
                    res_err  = 1'b1;
                end else begin
                    state_nx = S_LAUNCH;
                end
            end
            S_DONE:   state_nx = start ? S_CHECK : S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // captured request, results and outcome flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_mask <= '0;
            cap_sw   <= '0;
            cap_sh   <= '0;
            cap_dw   <= '0;
            cap_dh   <= '0;
            op       <= OP_HFAC;
            h_fac    <= '0;
            v_fac    <= '0;
            h_init_q <= '0;
            h_step_q <= '0;
            v_init_q <= '0;
            v_step_q <= '0;
            err_q    <= 1'b0;
            en_q     <= 1'b0;
        end else begin
            if (accept) begin
                cap_mask <= req_mask;
                cap_sw   <= src_w;
                cap_sh   <= src_h;
                cap_dw   <= dst_w;
                cap_dh   <= dst_h;
                op       <= OP_HFAC;
            end
            if (state == S_JUDGE) op <= OP_HINIT;
            if (state == S_WAIT && div_fin) begin
                unique case (op)
                    OP_HFAC:  begin h_fac <= div_quo; op <= OP_VFAC; end
                    OP_VFAC:  v_fac <= div_quo;
                    OP_HINIT: begin
                        h_init_q <= {1'b0, div_quo[FAC_W-1:1]} + FAC_W'(div_quo[0]);
                        op <= OP_HSTEP;
                    end
                    OP_HSTEP: begin h_step_q <= div_quo; op <= OP_VINIT; end
                    OP_VINIT: begin
                        v_init_q <= {1'b0, div_quo[FAC_W-1:1]} + FAC_W'(div_quo[0]);
                        op <= OP_VSTEP;
                    end
                    OP_VSTEP: v_step_q <= div_quo;
                    default: ;
                endcase
            end
            if (set_res) begin
                err_q <= res_err;
                en_q  <= res_en;
            end
        end
    end

    assign done     = (state == S_DONE);
    assign err      = err_q;
    assign scale_en = en_q;
    assign in_w     = iw;
    assign in_h     = ih;
    assign out_w    = cap_dw;
    assign out_h    = cap_dh;
    assign h_init   = h_init_q;
    assign h_step   = h_step_q;
    assign v_init   = v_init_q;
    assign v_step   = v_step_q;

    // R11: the completion pulse never lasts two cycles
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11 / R12: an accepted start always makes the block busy next cycle
    assert_busy_after_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    // R3: success is only ever reported for a single-plane request
    assert_single_plane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && scale_en) |-> ($countones(cap_mask) == 1));
    // R6: error and enable are never reported together
    assert_outcome_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(err && scale_en));
    // R9: an accepted request always selects the upscale sets
    assert_up_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && scale_en) |-> (h_coef == SET_UP && v_coef == SET_UP));
endmodule

// File: tb/sim_scale_param_calc.sv
`timescale 1ns/1ps
module sim_scale_param_calc;
    localparam int NP = 4;
    localparam int DW = 16;
    localparam int SW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NP-1:0] req_mask = '0;
    logic [SW-1:0] src_w = '0, src_h = '0;
    logic [DW-1:0] dst_w = '0, dst_h = '0;
    logic          busy, done, err, scale_en;
    logic [1:0]    plane_id;
    logic [DW-1:0] in_w, in_h, out_w, out_h;
    logic [31:0]   h_init, h_step, v_init, v_step;
    logic [2:0]    h_coef, v_coef;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    scale_param_calc #(.NPLANES(NP), .DIM_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .req_mask(req_mask),
        .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
        .busy(busy), .done(done), .err(err), .scale_en(scale_en),
        .plane_id(plane_id), .in_w(in_w), .in_h(in_h), .out_w(out_w),
        .out_h(out_h), .h_init(h_init), .h_step(h_step), .v_init(v_init),
        .v_step(v_step), .h_coef(h_coef), .v_coef(v_coef)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int exp_set(input longint f);
        if (f >= 64'h10000) return 1;
        if (f >= 64'hAAAA)  return 2;
        if (f >= 64'h8000)  return 3;
        if (f >= 64'h5D17)  return 4;
        return 5;
    endfunction

    task automatic wait_done();
        int n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL R11 watchdog: done never rose actual=0 expected=1");
        end
    endtask

    task automatic drive(input logic [NP-1:0] m, input longint sw, input longint sh,
                         input longint dw, input longint dh);
        req_mask = m;
        src_w = sw[SW-1:0];
        src_h = sh[SW-1:0];
        dst_w = dw[DW-1:0];
        dst_h = dh[DW-1:0];
        start = 1'b1;
    endtask

    // judge outputs at the done cycle against arithmetic expectations
    task automatic judge(input logic [NP-1:0] m, input longint sw, input longint sh,
                         input longint dw, input longint dh);
        longint fh, fv, iw, ih;
        int pid;
        chk("R11 done at result", done, 1);
        if (m == 0) begin
            chk("R2 empty err", err, 0);
            chk("R2 empty en", scale_en, 0);
            return;
        end
        if ((m & (m - 1)) != 0) begin
            chk("R3 multi err", err, 1);
            chk("R3 multi en", scale_en, 0);
            return;
        end
        if (sw == 0 || sh == 0 || dw == 0 || dh == 0) begin
            chk("R4 zero err", err, 1);
            chk("R4 zero en", scale_en, 0);
            return;
        end
        fh = ((dw << 32) / sw) & 64'hFFFF_FFFF;
        fv = ((dh << 32) / sh) & 64'hFFFF_FFFF;
        chk("R9 h set", h_coef, exp_set(fh));
        chk("R9 v set", v_coef, exp_set(fv));
        if ((fh >> 16) == 0 || (fv >> 16) == 0) begin
            chk("R5 downscale err", err, 1);
            chk("R5 downscale en", scale_en, 0);
            return;
        end
        iw = sw >> 16;
        ih = sh >> 16;
        pid = 0;
        for (int i = 0; i < NP; i++) if (m[i]) pid = i;
        chk("R6 err", err, 0);
        chk("R6 en", scale_en, 1);
        chk("R6 in_w", in_w, iw);
        chk("R6 in_h", in_h, ih);
        chk("R6 out_w", out_w, dw);
        chk("R6 out_h", out_h, dh);
        chk("R7 h_init", h_init, (((iw << 4) / dw) + 1) / 2);
        chk("R7 v_init", v_init, (((ih << 4) / dh) + 1) / 2);
        chk("R8 h_step", h_step, (iw << 16) / dw);
        chk("R8 v_step", v_step, (ih << 16) / dh);
        chk("R10 plane", plane_id, pid);
    endtask

    task automatic run(input logic [NP-1:0] m, input longint sw, input longint sh,
                       input longint dw, input longint dh);
        @(negedge clk);
        drive(m, sw, sh, dw, dh);
        @(negedge clk);
        start = 1'b0;
        chk("R11 busy after start", busy, 1);
        wait_done();
        judge(m, sw, sh, dw, dh);
        @(negedge clk);
        chk("R11 done single cycle", done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL R11 global watchdog actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy reset", busy, 0);
        chk("R1 done reset", done, 0);
        chk("R1 err reset", err, 0);
        chk("R1 en reset", scale_en, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // every mask value with good dimensions (R2, R3, R10)
        for (int m = 0; m < 16; m++)
            run(NP'(m), 64'h0002_0000, 64'h0003_4000, 40, 50);

        // R2: empty mask with zero dimensions is still no error
        run('0, 0, 0, 0, 0);
        // R4: each zero dimension alone
        run(4'b0010, 0, 64'h10000, 5, 5);
        run(4'b0010, 64'h10000, 0, 5, 5);
        run(4'b0100, 64'h10000, 64'h10000, 0, 5);
        run(4'b1000, 64'h10000, 64'h10000, 5, 0);

        // R9 / R5 boundaries around each threshold
        run(4'b0001, 64'h10000, 64'h10000, 1, 1);
        run(4'b0001, 64'h10001, 64'h10000, 1, 1);
        run(4'b0001, 64'h18000, 64'h18001, 1, 1);
        run(4'b0001, 64'h20000, 64'h20001, 1, 1);
        run(4'b0001, 64'h2C000, 64'h2C100, 1, 1);
        run(4'b0001, 64'h40000, 64'h8000, 1, 1);

        // sweep of sizes, mixing upscale and downscale (R5..R10)
        for (int a = 1; a <= 6; a++)
            for (int d = 1; d <= 24; d++)
                run(NP'(1 << (d % 4)), (longint'(a) << 16) | longint'((d % 3) * 16'h4000),
                    (longint'(a + 1) << 16) | 64'h8000, d, d + 3);

        // R11: a start while busy is ignored
        @(negedge clk);
        drive(4'b0100, 64'h30000, 64'h20000, 100, 90);
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        drive(4'b1000, 64'h50000, 64'h50000, 7, 9);
        @(negedge clk);
        start = 1'b0;
        wait_done();
        judge(4'b0100, 64'h30000, 64'h20000, 100, 90);

        // R12: start in the done cycle is accepted
        drive(4'b0010, 64'h40000, 64'h60000, 33, 77);
        @(negedge clk);
        start = 1'b0;
        chk("R12 busy after start in done cycle", busy, 1);
        wait_done();
        judge(4'b0010, 64'h40000, 64'h60000, 33, 77);
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule